// File: doc/BRIEF.md
# Line Status Interrupt Register

This block collects six real-time line status conditions for a single-channel T1/E1/J1 line interface and turns them into one interrupt request. Four of the conditions arrive as level inputs from detectors that lie outside the block: in-band loopback deactivate code seen, in-band loopback activate code seen, pseudo-random pattern sync, and equalizer out of range. A fifth, line driver short circuit, also arrives as a level input. The sixth, transmit clock loss, is produced inside the block. A watchdog counts master clock cycles between edges of the transmit clock, after the clock has been brought into the master domain.

Software reads a live status byte. For each condition it selects a mask and a trigger mode, which is either rising edge only or any change. Conditions that pass the mask set sticky pending flags. Software clears a flag by writing 1 to it. The interrupt output is active high and is the OR of all pending flags.

The clock-loss watchdog is a two-state machine. In state CLK_OK it counts cycles without a transmit-clock edge. It takes the transition CLK_OK→CLK_LOST when the count reaches the loss limit while no edge is present. In state CLK_LOST it takes the transition CLK_LOST→CLK_OK on the first synchronised edge. Any edge resets the count.

Top module: `lsr_irq_top`

## Requirements
- R1: After reset the registers read as follows: status (0x17) = 0x00, mask (0x18) = 0xFC, edge-select (0x19) = 0x00, pending (0x1A) = 0x00. The interrupt output is 0.
- R2: Status byte 0x17 reflects the inputs with this layout: bit 7 loopback deactivate, bit 6 loopback activate, bit 5 pattern sync, bit 4 transmit clock loss, bit 3 equalizer out of range (1 = out of range), bit 2 driver short (1 = short detected). The byte reflects the inputs one master clock after they change. Bits 1:0 read 0.
- R3: The status byte is read-only. A write to 0x17 does not change what it reads.
- R4: Status bit 4 stays 0 while the transmit clock keeps toggling. It becomes 1 once the transmit clock has not toggled for more than LOSS_LIMIT (70) master clocks, no later than LOSS_LIMIT+8 master clocks after the last toggle.
- R5: After a loss, status bit 4 returns to 0 within 8 master clocks of the first transmit clock toggle.
- R6: A status bit whose mask bit is 1 never sets its pending flag.
- R7: With its edge-select bit at 0 and its mask bit at 0, a status bit sets its pending flag on a 0→1 change only. A 1→0 change has no effect.
- R8: With its edge-select bit at 1 and its mask bit at 0, a status bit sets its pending flag on any change.
- R9: Pending flags at 0x1A use the same bit positions as the status byte. A flag stays set until 1 is written to that bit. Writing 0 leaves the flag unchanged.
- R10: The interrupt output is 1 exactly when at least one pending flag is set.
- R11: The mask (0x18) and edge-select (0x19) registers read back the written bits 7:2. Bits 1:0 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| txclk_in | input | 1 | Transmit clock, asynchronous to clk |
| lb_deact_in | input | 1 | Loopback deactivate code detected (level) |
| lb_act_in | input | 1 | Loopback activate code detected (level) |
| prbs_sync_in | input | 1 | Pseudo-random pattern in sync (level) |
| eq_oor_in | input | 1 | Equalizer out of range (level) |
| drv_short_in | input | 1 | Line driver short circuit (level) |
| addr | input | 8 | Register address |
| wr_en | input | 1 | Write strobe, sampled on clk |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from addr |
| irq | output | 1 | Interrupt request, active high |

## Verification
A level input reaches the status byte and its pending flag at the first rising clock edge after it changes. The interrupt follows the pending flags in the same cycle. The bench therefore drives on a falling edge and samples at the next falling edge or later.

The loss bit passes through a three-flop synchroniser and edge detector, the counter, the state register and the status register. Loss checks are therefore taken well clear of the limit: once at 60 cycles after the clock stops and once at 90. The release is checked 12 cycles after the clock restarts.

Register writes take effect at the edge inside the write strobe. Reads are combinational and are sampled once that edge has passed.

// File: rtl/lsr_pkg.sv
package lsr_pkg;
    localparam int NSTAT   = 6;
    localparam int LSB_POS = 2;
    localparam int BYTE_W  = NSTAT + LSB_POS;

    typedef logic [NSTAT-1:0] stat_t;

    typedef enum logic {
        CLK_OK,
        CLK_LOST
    } txmon_st_e;

    function automatic logic [BYTE_W-1:0] to_byte(stat_t s);
        return {s, {LSB_POS{1'b0}}};
    endfunction
endpackage

// File: rtl/lsr_txclk_mon.sv
module lsr_txclk_mon #(
    parameter int LOSS_LIMIT = 70
) (
    input  logic clk,
    input  logic rst_n,
    input  logic txclk_in,
    output logic loss_o
);
    import lsr_pkg::*;

    localparam int CW = $clog2(LOSS_LIMIT + 1);

    logic [2:0]  sync_q;
    logic        tx_edge;
    logic [CW-1:0] cnt_q;
    txmon_st_e   state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[1:0], txclk_in};
    end

    assign tx_edge = sync_q[2] ^ sync_q[1];

    always_ff @(posedge clk) begin
        if (!rst_n)                         cnt_q <= '0;
        else if (tx_edge)                   cnt_q <= '0;
        else if (cnt_q != CW'(LOSS_LIMIT))  cnt_q <= cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CLK_OK;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CLK_OK:   if (!tx_edge && cnt_q == CW'(LOSS_LIMIT)) state_d = CLK_LOST;
            CLK_LOST: if (tx_edge) state_d = CLK_OK;
            default:  state_d = CLK_OK;
        endcase
    end

    always_comb begin
        loss_o = (state_q == CLK_LOST);
    end

    // R4
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(LOSS_LIMIT));

    // R4
    no_false_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CLK_OK && tx_edge) |=> !loss_o);

    // R5
    loss_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CLK_LOST && tx_edge) |=> !loss_o);
endmodule

// File: rtl/lsr_evt_unit.sv
module lsr_evt_unit
    import lsr_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  stat_t stat_in,
    input  stat_t mask,
    input  stat_t edge_sel,
    input  stat_t clr,
    output stat_t stat_q,
    output stat_t pend_q
);
    stat_t hit;

    for (genvar i = 0; i < NSTAT; i++) begin : g_bit
        always_comb begin
            if (mask[i])          hit[i] = 1'b0;
            else if (edge_sel[i]) hit[i] = stat_in[i] ^ stat_q[i];
            else                  hit[i] = stat_in[i] & ~stat_q[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
            pend_q <= '0;
        end else begin
            stat_q <= stat_in;
            pend_q <= (pend_q & ~clr) | hit;
        end
    end

    // R6
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q & ~$past(pend_q) & $past(mask)) == '0);

    // R7
    rise_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q & ~$past(pend_q) & ~$past(edge_sel) & ~(stat_q & ~$past(stat_q))) == '0);

    // R9
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pend_q) & ~$past(clr) & ~pend_q) == '0);
endmodule

// File: rtl/lsr_regbus.sv
module lsr_regbus
    import lsr_pkg::*;
#(
    parameter logic [7:0] STAT_ADDR = 8'h17,
    parameter logic [7:0] MASK_ADDR = 8'h18,
    parameter logic [7:0] EDGE_ADDR = 8'h19,
    parameter logic [7:0] PEND_ADDR = 8'h1A
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  addr,
    input  logic        wr_en,
    input  logic [7:0]  wdata,
    input  stat_t       stat_q,
    input  stat_t       pend_q,
    output stat_t       mask_q,
    output stat_t       edge_q,
    output stat_t       clr,
    output logic [7:0]  rdata
);
    stat_t wfield;
    assign wfield = wdata[BYTE_W-1:LSB_POS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '1;
            edge_q <= '0;
        end else if (wr_en) begin
            if (addr == MASK_ADDR) mask_q <= wfield;
            if (addr == EDGE_ADDR) edge_q <= wfield;
        end
    end

    assign clr = (wr_en && addr == PEND_ADDR) ? wfield : '0;

    always_comb begin
        case (addr)
            STAT_ADDR: rdata = to_byte(stat_q);
            MASK_ADDR: rdata = to_byte(mask_q);
            EDGE_ADDR: rdata = to_byte(edge_q);
            PEND_ADDR: rdata = to_byte(pend_q);
            default:   rdata = '0;
        endcase
    end

    // R11
    mask_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == MASK_ADDR) |=> mask_q == $past(wfield));

    // R11
    edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == EDGE_ADDR) |=> $stable(edge_q));
endmodule

// File: rtl/lsr_irq_top.sv
module lsr_irq_top
    import lsr_pkg::*;
#(
    parameter int LOSS_LIMIT = 70
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       txclk_in,
    input  logic       lb_deact_in,
    input  logic       lb_act_in,
    input  logic       prbs_sync_in,
    input  logic       eq_oor_in,
    input  logic       drv_short_in,
    input  logic [7:0] addr,
    input  logic       wr_en,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       irq
);
    logic  loss;
    stat_t stat_in, stat_q, pend_q, mask_q, edge_q, clr;

    lsr_txclk_mon #(.LOSS_LIMIT(LOSS_LIMIT)) u_mon (
        .clk(clk), .rst_n(rst_n), .txclk_in(txclk_in), .loss_o(loss)
    );

    assign stat_in = {lb_deact_in, lb_act_in, prbs_sync_in, loss, eq_oor_in, drv_short_in};

    lsr_evt_unit u_evt (
        .clk(clk), .rst_n(rst_n), .stat_in(stat_in), .mask(mask_q),
        .edge_sel(edge_q), .clr(clr), .stat_q(stat_q), .pend_q(pend_q)
    );

    lsr_regbus u_bus (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
        .stat_q(stat_q), .pend_q(pend_q), .mask_q(mask_q), .edge_q(edge_q),
        .clr(clr), .rdata(rdata)
    );

    assign irq = |pend_q;

    // R10
    irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(clr != '0));
endmodule

// File: tb/lsr_irq_top_tb_top.sv
`timescale 1ns/1ps
module lsr_irq_top_tb_top;
    logic clk = 1'b0, rst_n = 1'b0, txclk = 1'b0;
    logic deact = 0, act = 0, prbs = 0, eq = 0, drv = 0;
    logic [7:0] addr = 8'h00, wdata = 8'h00, rdata;
    logic wr_en = 1'b0, irq;
    logic txrun = 1'b0;
    int   tdiv = 0;
    int   n_chk = 0, n_fail = 0;
    bit   done = 1'b0;

    always #10 clk = ~clk;

    always @(negedge clk) begin
        if (txrun) begin
            if (tdiv == 2) begin tdiv <= 0; txclk <= ~txclk; end
            else tdiv <= tdiv + 1;
        end
    end

    lsr_irq_top dut_i (
        .clk(clk), .rst_n(rst_n), .txclk_in(txclk), .lb_deact_in(deact),
        .lb_act_in(act), .prbs_sync_in(prbs), .eq_oor_in(eq), .drv_short_in(drv),
        .addr(addr), .wr_en(wr_en), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    // mask, edge, from, to (6-bit fields = byte bits 7:2; field bit 2 is clock loss, kept 0)
    localparam logic [23:0] VECS [6] = '{
        {6'b000000, 6'b000000, 6'b000000, 6'b111011},
        {6'b000000, 6'b000000, 6'b111011, 6'b000000},
        {6'b000000, 6'b111011, 6'b111011, 6'b000000},
        {6'b111011, 6'b111011, 6'b000000, 6'b111011},
        {6'b101000, 6'b000011, 6'b010001, 6'b101010},
        {6'b000000, 6'b000000, 6'b000001, 6'b000011}
    };

    task automatic check(input string req, input logic [7:0] act_v, input logic [7:0] exp_v);
        n_chk++;
        if (act_v !== exp_v) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, act_v, exp_v);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        addr = a; #1; d = rdata;
    endtask

    task automatic drive(input logic [5:0] s);
        @(negedge clk);
        deact = s[5]; act = s[4]; prbs = s[3]; eq = s[1]; drv = s[0];
    endtask

    function automatic logic [5:0] model(input logic [5:0] m, e, f, t);
        return ~m & ((e & (f ^ t)) | (~e & ~f & t)) & 6'b111011;
    endfunction

    initial begin : wdog
        #(20ns * 200000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd(8'h17, v); check("R1 status", v, 8'h00);
        rd(8'h18, v); check("R1 mask", v, 8'hFC);
        rd(8'h19, v); check("R1 edge", v, 8'h00);
        rd(8'h1A, v); check("R1 pending", v, 8'h00);
        check("R1 irq", {7'd0, irq}, 8'h00);
        txrun = 1'b1;

        // R11 register read-back
        wr(8'h18, 8'hFF); @(negedge clk); rd(8'h18, v); check("R11 mask", v, 8'hFC);
        wr(8'h19, 8'h57); @(negedge clk); rd(8'h19, v); check("R11 edge", v, 8'h54);
        wr(8'h19, 8'h00);

        // R2 status layout, R3 read-only
        drive(6'b101001); @(negedge clk);
        rd(8'h17, v); check("R2 layout", v, 8'hA4);
        wr(8'h17, 8'hFF); @(negedge clk);
        rd(8'h17, v); check("R3 read-only", v, 8'hA4);
        drive(6'b000000); @(negedge clk);

        // table walk: R6 R7 R8 R10
        for (int i = 0; i < 6; i++) begin
            logic [5:0] m, e, f, t, x;
            {m, e, f, t} = VECS[i];
            x = model(m, e, f, t);
            wr(8'h18, {m, 2'b00});
            wr(8'h19, {e, 2'b00});
            drive(f); @(negedge clk);
            wr(8'h1A, 8'hFC); @(negedge clk);
            drive(t); @(negedge clk); @(negedge clk);
            rd(8'h1A, v); check("R6/R7/R8 pending", v, {x, 2'b00});
            check("R10 irq", {7'd0, irq}, {7'd0, |x});
        end
        drive(6'b000000);

        // R4 clock loss
        wr(8'h18, 8'hEC); wr(8'h19, 8'h00); @(negedge clk);
        wr(8'h1A, 8'hFC); @(negedge clk);
        txrun = 1'b0;
        repeat (60) @(negedge clk);
        rd(8'h17, v); check("R4 no early loss", v & 8'h10, 8'h00);
        repeat (30) @(negedge clk);
        rd(8'h17, v); check("R4 loss set", v & 8'h10, 8'h10);
        rd(8'h1A, v); check("R4 loss pending", v, 8'h10);
        check("R10 irq on loss", {7'd0, irq}, 8'h01);

        // R5 release
        txrun = 1'b1;
        repeat (12) @(negedge clk);
        rd(8'h17, v); check("R5 loss cleared", v & 8'h10, 8'h00);

        // R9 sticky and clear
        rd(8'h1A, v); check("R9 sticky after release", v, 8'h10);
        wr(8'h1A, 8'h00); @(negedge clk);
        rd(8'h1A, v); check("R9 write 0 keeps", v, 8'h10);
        wr(8'h1A, 8'h10); @(negedge clk);
        rd(8'h1A, v); check("R9 write 1 clears", v, 8'h00);
        check("R10 irq low", {7'd0, irq}, 8'h00);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule